// File: doc/BRIEF.md
# Sub-Addressed I2C Target with Staged Register Commit

This block is an I2C target that gives a bus master access to fourteen 8-bit command registers. It samples SCL and SDA with the system clock through two-flop synchronizers. It detects START, repeated START and STOP, and answers to the fixed 7-bit address 0x34. That address gives the byte 0x68 for writes and 0x69 for reads. SDA is driven only as an open-drain pull-down enable.

A write transaction sends a sub-address and then a data byte. Further sub-address and data pairs may follow in the same transaction. Each data byte is stored in a holding latch. The live registers, which feed the parallel output, copy all holding latches at once only when a STOP is seen on the bus. Repeated STARTs in between, including ones aimed at other devices, leave the staged data untouched.

Reads return the holding latch selected by a stored pointer. A master can therefore check staged data before it commits it. It can also poll a register with only START and the read address.

Top module: `i2c_staged_regs`

## Requirements
- R1: Only the address byte 0x68 (write) or 0x69 (read), whose upper seven bits are 0x34 and whose bit 0 is the read/write flag, is acknowledged. After any other address byte, SDA stays released and later bytes get no acknowledge until the next START or STOP.
- R2: After the write address, bytes alternate between sub-address and data, so several register pairs can be written in one transaction.
- R3: For a matching address, a valid sub-address and each data byte, `sda_oe_o` is high for the whole time SCL is high during the ninth clock.
- R4: A data byte is stored in the holding latch selected by the preceding sub-address, at the point where its acknowledge begins.
- R5: `regs_o` (register n on bits [8n+7:8n]) changes only on a STOP. At a STOP it takes a copy of all fourteen holding latches.
- R6: A repeated START to another device's address keeps all staged data, and the commit still happens at the following STOP.
- R7: After the read address is acknowledged, the block shifts out 8 bits, most significant first, one per SCL clock. A master ACK makes it send the same register again. A master NACK releases SDA until the next START or STOP.
- R8: The read pointer keeps its value across transactions until a new valid sub-address is written, so START plus read address alone reads the same register again.
- R9: A read returns the holding latch contents, including data staged but not yet committed.
- R10: A sub-address of 14 or higher is not acknowledged. It changes neither the read pointer nor any latch, and the bytes that follow it are ignored.
- R11: Reset clears the holding latches, the live registers and the read pointer to zero, and releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |
| regs_o | output | 112 | Live command registers, register n on bits [8n+7:8n] |

## Verification
Two functions can disagree about the same register at the same moment: the staged read path and the live output. Between a write and its STOP, the holding latch carries the new value while `regs_o` still carries the old one. The bench stages all fourteen registers in one transaction and reads each one back through repeated STARTs. It checks that every read returns the staged value while `regs_o` stays at its previous contents. It then issues a STOP and compares all fourteen live slices against values computed arithmetically in the bench.

// File: rtl/i2c_sr_pkg.sv
package i2c_sr_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_DATA,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_SKIP
  } link_st_e;
endpackage

// File: rtl/i2c_sr_sync.sv
module i2c_sr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_prev_q, sda_prev_q;
  logic scl_s, sda_s;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
    end
  endgenerate

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_prev_q;
  assign scl_fall_o = ~scl_s & scl_prev_q;
  // SDA edge while SCL stays high
  assign start_o    = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
  assign stop_o     = scl_s & scl_prev_q & ~sda_prev_q & sda_s;

  p_no_edge_in_cond_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o || stop_o) |-> !(scl_rise_o || scl_fall_o));
endmodule

// File: rtl/i2c_sr_link.sv
module i2c_sr_link
  import i2c_sr_pkg::*;
#(
  parameter int          NUM_REGS = 14,
  parameter logic [6:0]  DEV_ADDR = 7'h34,
  localparam int         PTR_W    = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic              wr_en_o,
  output logic [PTR_W-1:0]  wr_idx_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic [PTR_W-1:0]  ptr_o
);
  link_st_e          state_q, nxt_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic [PTR_W-1:0]  ptr_q;
  logic              oe_q, mnack_q;
  logic              byte_done, sub_ok, rx_state;

  assign byte_done = (cnt_q == CNT_W'(BYTE_W));
  assign sub_ok    = (sh_q < BYTE_W'(NUM_REGS));
  assign rx_state  = (state_q == ST_ADDR) || (state_q == ST_SUB) || (state_q == ST_DATA);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      nxt_q   <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      oe_q    <= 1'b0;
      mnack_q <= 1'b1;
    end else if (start_i) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else if (rx_state) begin
      if (scl_rise_i && !byte_done) begin
        sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
        cnt_q <= cnt_q + 1'b1;
      end else if (scl_fall_i && byte_done) begin
        cnt_q <= '0;
        if (state_q == ST_ADDR) begin
          if (sh_q[7:1] == DEV_ADDR) begin
            oe_q    <= 1'b1;
            state_q <= ST_ACK;
            nxt_q   <= sh_q[0] ? ST_TX : ST_SUB;
          end else begin
            state_q <= ST_SKIP;
          end
        end else if (state_q == ST_SUB) begin
          if (sub_ok) begin
            oe_q    <= 1'b1;
            ptr_q   <= sh_q[PTR_W-1:0];
            state_q <= ST_ACK;
            nxt_q   <= ST_DATA;
          end else begin
            state_q <= ST_SKIP;
          end
        end else begin
          oe_q    <= 1'b1;
          state_q <= ST_ACK;
          nxt_q   <= ST_SUB;
        end
      end
    end else begin
      unique case (state_q)
        ST_ACK: if (scl_fall_i) begin
          state_q <= nxt_q;
          if (nxt_q == ST_TX) begin
            sh_q <= rd_data_i;
            oe_q <= ~rd_data_i[BYTE_W-1];
          end else begin
            oe_q <= 1'b0;
          end
        end
        ST_TX: if (scl_fall_i) begin
          if (cnt_q == CNT_W'(BYTE_W - 1)) begin
            oe_q    <= 1'b0;
            cnt_q   <= '0;
            state_q <= ST_MACK;
          end else begin
            cnt_q <= cnt_q + 1'b1;
            sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
            oe_q  <= ~sh_q[BYTE_W-2];
          end
        end
        ST_MACK: begin
          if (scl_rise_i) mnack_q <= sda_i;
          else if (scl_fall_i) begin
            if (!mnack_q) begin
              state_q <= ST_TX;
              sh_q    <= rd_data_i;
              oe_q    <= ~rd_data_i[BYTE_W-1];
            end else begin
              state_q <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end

  assign sda_oe_o  = oe_q;
  assign wr_en_o   = (state_q == ST_DATA) && scl_fall_i && byte_done && !start_i && !stop_i;
  assign wr_idx_o  = ptr_q;
  assign wr_data_o = sh_q;
  assign ptr_o     = ptr_q;

  p_start_release_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !sda_oe_o);
  p_skip_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SKIP) |-> !sda_oe_o);
  p_ack_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACK && scl_rise_i) |-> sda_oe_o);
  p_bad_sub_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SUB && scl_fall_i && byte_done && !sub_ok && !start_i && !stop_i)
      |=> (!sda_oe_o && ptr_q == $past(ptr_q)));
  p_mack_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_MACK) |-> !sda_oe_o);
endmodule

// File: rtl/i2c_sr_regfile.sv
module i2c_sr_regfile
  import i2c_sr_pkg::*;
#(
  parameter int  NUM_REGS = 14,
  localparam int PTR_W    = $clog2(NUM_REGS),
  localparam int FLAT_W   = NUM_REGS * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [PTR_W-1:0]  wr_idx_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              commit_i,
  input  logic [PTR_W-1:0]  rd_idx_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic [FLAT_W-1:0] live_o
);
  logic [FLAT_W-1:0] hold_flat, live_flat;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [BYTE_W-1:0] hold_q, live_q;

    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) begin
        hold_q <= '0;
        live_q <= '0;
      end else begin
        if (wr_en_i && wr_idx_i == PTR_W'(g)) hold_q <= wr_data_i;
        if (commit_i) live_q <= hold_q;
      end

    assign hold_flat[g*BYTE_W +: BYTE_W] = hold_q;
    assign live_flat[g*BYTE_W +: BYTE_W] = live_q;

    p_stage_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_idx_i == PTR_W'(g)) |=> hold_q == $past(wr_data_i));
  end

  assign rd_data_o = (int'(rd_idx_i) < NUM_REGS) ? hold_flat[int'(rd_idx_i)*BYTE_W +: BYTE_W] : '0;
  assign live_o    = live_flat;

  p_live_steady_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(live_flat));
  p_commit_copy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> live_flat == $past(hold_flat));
endmodule

// File: rtl/i2c_staged_regs.sv
module i2c_staged_regs
  import i2c_sr_pkg::*;
#(
  parameter int         NUM_REGS    = 14,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h34
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_oe_o,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
  localparam int PTR_W = $clog2(NUM_REGS);

  logic sda_s, scl_rise, scl_fall, start, stop;
  logic wr_en;
  logic [PTR_W-1:0]  wr_idx, ptr;
  logic [BYTE_W-1:0] wr_data, rd_data;

  i2c_sr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  i2c_sr_link #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) u_link (
    .clk_i, .rst_ni, .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start), .stop_i(stop), .rd_data_i(rd_data),
    .sda_oe_o, .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data), .ptr_o(ptr)
  );

  i2c_sr_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .commit_i(stop), .rd_idx_i(ptr), .rd_data_o(rd_data), .live_o(regs_o)
  );

  p_commit_on_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(regs_o) |-> $past(stop));
endmodule

// File: tb/i2c_staged_regs_test.sv
`timescale 1ns/1ps
module i2c_staged_regs_test;
  localparam int N = 14;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [N*8-1:0] regs;
  logic sda_line;
  int checks = 0, fails = 0;
  logic done = 1'b0;
  logic [7:0] exp_live [N];

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_staged_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .regs_o(regs)
  );

  function automatic logic [7:0] fval(int i, int k);
    return 8'((i * 37 + 5 + k * 91) & 255);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  // one SCL clock; all_low: line low during entire high phase
  task automatic clk_bit(input logic b, output logic all_low, output logic mid);
    sda_m = b; wq(); scl_m = 1'b1;
    all_low = 1'b1;
    for (int k = 0; k < 2 * Q; k++) begin
      @(negedge clk);
      if (sda_line) all_low = 1'b0;
      if (k == Q) mid = sda_line;
    end
    scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic al, md;
    for (int k = 7; k >= 0; k--) clk_bit(b[k], al, md);
    clk_bit(1'b1, ack, md);
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] d);
    logic al, md;
    for (int k = 7; k >= 0; k--) begin
      clk_bit(1'b1, al, md);
      d[k] = md;
    end
    clk_bit(!m_ack, al, md);
  endtask

  task automatic check_live(string tag);
    for (int i = 0; i < N; i++) chk(tag, 32'(regs[i*8 +: 8]), 32'(exp_live[i]));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    for (int i = 0; i < N; i++) exp_live[i] = 8'h00;
    repeat (5) @(negedge clk);
    // R11 reset state
    chk("R11 regs after reset", 32'(regs == '0), 32'd1);
    chk("R11 sda released", 32'(sda_oe), 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 address sweep
    for (int a = 0; a < 128; a++) begin
      i2c_start();
      send_byte({7'(a), 1'b0}, ack);
      chk("R1 address ack", 32'(ack), 32'(a == 'h34));
      if (a != 'h34) begin
        send_byte(8'h00, ack);
        chk("R1 ignored after mismatch", 32'(ack), 32'd0);
      end
      i2c_stop();
    end
    check_live("R5 no change from sweep");

    // R2/R3/R4: stage all registers in one transaction
    i2c_start();
    send_byte(8'h68, ack);
    chk("R3 write address ack", 32'(ack), 32'd1);
    for (int i = 0; i < N; i++) begin
      send_byte(8'(i), ack);
      chk("R2 sub ack", 32'(ack), 32'd1);
      send_byte(fval(i, 0), ack);
      chk("R3 data ack", 32'(ack), 32'd1);
    end
    chk("R5 live unchanged before stop", 32'(regs == '0), 32'd1);
    // R9/R7: verify staged via repeated start reads
    for (int i = 0; i < N; i++) begin
      i2c_start();
      send_byte(8'h68, ack);
      send_byte(8'(i), ack);
      i2c_start();
      send_byte(8'h69, ack);
      chk("R7 read address ack", 32'(ack), 32'd1);
      recv_byte(1'b0, d);
      chk("R9 staged readback", 32'(d), 32'(fval(i, 0)));
    end
    chk("R5 live unchanged after reads", 32'(regs == '0), 32'd1);
    // R6 other device in between
    i2c_start();
    send_byte(8'hA0, ack);
    chk("R6 other device no ack", 32'(ack), 32'd0);
    send_byte(8'h03, ack);
    chk("R6 other device bytes ignored", 32'(ack), 32'd0);
    chk("R6 live unchanged before stop", 32'(regs == '0), 32'd1);
    i2c_stop();
    for (int i = 0; i < N; i++) exp_live[i] = fval(i, 0);
    check_live("R6 R5 commit at stop");

    // R7 multi-byte read with master ack
    i2c_start();
    send_byte(8'h68, ack);
    send_byte(8'd5, ack);
    i2c_start();
    send_byte(8'h69, ack);
    recv_byte(1'b1, d);
    chk("R7 first byte", 32'(d), 32'(fval(5, 0)));
    recv_byte(1'b0, d);
    chk("R7 repeat after master ack", 32'(d), 32'(fval(5, 0)));
    chk("R7 released after nack", 32'(sda_oe), 32'd0);
    i2c_stop();

    // R8 polling without sub-address
    for (int p = 0; p < 2; p++) begin
      i2c_start();
      send_byte(8'h69, ack);
      recv_byte(1'b0, d);
      chk("R8 poll same pointer", 32'(d), 32'(fval(5, 0)));
    end
    i2c_stop();

    // R10 invalid sub-addresses
    for (int s = 14; s < 20; s++) begin
      i2c_start();
      send_byte(8'h68, ack);
      send_byte(8'(s), ack);
      chk("R10 bad sub nack", 32'(ack), 32'd0);
      send_byte(8'hEE, ack);
      chk("R10 following byte ignored", 32'(ack), 32'd0);
      i2c_stop();
    end
    i2c_start();
    send_byte(8'h68, ack);
    send_byte(8'hFF, ack);
    chk("R10 sub 0xFF nack", 32'(ack), 32'd0);
    i2c_stop();
    check_live("R10 no register changed");
    i2c_start();
    send_byte(8'h69, ack);
    recv_byte(1'b0, d);
    chk("R10 pointer kept", 32'(d), 32'(fval(5, 0)));
    i2c_stop();

    // R4/R5 single-pair transactions, one register per commit
    for (int i = 0; i < N; i += 3) begin
      i2c_start();
      send_byte(8'h68, ack);
      send_byte(8'(i), ack);
      send_byte(fval(i, 1), ack);
      chk("R4 data ack", 32'(ack), 32'd1);
      check_live("R5 hold until stop");
      i2c_stop();
      exp_live[i] = fval(i, 1);
      check_live("R4 R5 single commit");
    end

    // R11 reset mid-run
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 regs cleared", 32'(regs == '0), 32'd1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    i2c_start();
    send_byte(8'h69, ack);
    recv_byte(1'b0, d);
    chk("R11 pointer and latch zero", 32'(d), 32'd0);
    i2c_stop();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule